// File: doc/BRIEF.md
# 8-bit ALU with five-flag condition code

This block is the arithmetic and logic core of a small 8-bit controller datapath. Each cycle it takes an operation code, two operands (A and B) and an enable. When the enable is high, it computes the operation. The 8-bit result and a five-bit condition-code register are then updated on the next rising clock edge. Carry-in for the carry-chained operations and for the rotates comes from the carry flag held inside the block. A sequence of operations therefore chains naturally, and operand fetch stays with the surrounding datapath.

Both outputs are registered and are the block's architectural state. Compare, bit-test and test update only the flags and keep the previous result. The flag commands change one flag bit and nothing else. Reset clears the result and leaves only the interrupt-mask flag set.

Top module: `ccr_alu`

## Requirements
- R1: The flag output holds C in bit 0, Z in bit 1, N in bit 2, I (interrupt mask) in bit 3 and H (half carry) in bit 4. During and after reset the result is 0x00 and the flags are 0x08. Whenever an operation that updates N and Z executes, N is bit 7 of its 8-bit value and Z is 1 exactly when that value is zero.
- R2: With `en` high, the operation on `op` executes and its effect is visible on `result` and `flags` after the next rising clock edge. With `en` low, both outputs hold. The op codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 AND, 6 OR, 7 XOR, 8 bit test, 9 increment, 10 decrement, 11 negate, 12 complement, 13 clear, 14 test, 15 shift left, 16 logical shift right, 17 arithmetic shift right, 18 rotate left through carry, 19 rotate right through carry, 20 set C, 21 clear C, 22 set I, 23 clear I.
- R3: Add (0) writes A+B and add with carry (1) writes A+B+C. C becomes bit 8 of the 9-bit sum, H becomes bit 4 of (A xor B xor result), and I is kept.
- R4: Subtract (2) writes A-B and subtract with carry (3) writes A-B-C, both modulo 256. C is set exactly when B (plus the incoming C for code 3) exceeds A as unsigned numbers. H and I are kept.
- R5: Compare (4) sets flags as subtract. Bit test (8) sets N and Z as AND. Test (14) sets N and Z from A. None of the three changes `result`, and test and bit test keep C, H and I.
- R6: AND, OR and XOR (5 to 7) write the bitwise result, update N and Z, and keep C, H and I.
- R7: Increment (9) writes A+1 and decrement (10) writes A-1, modulo 256. Only N and Z change.
- R8: Negate (11) writes 0-A with C set when A is non-zero. Complement (12) writes the inverse of A and sets C. Clear (13) writes 0x00 and keeps C. All three keep H and I.
- R9: The shifts operate on A and load C with the bit shifted out. Shift left fills bit 0 with 0. Logical shift right fills bit 7 with 0. Arithmetic shift right copies bit 7. Rotate left fills bit 0 with the old C. Rotate right fills bit 7 with the old C. H and I are kept.
- R10: Codes 20 to 23 force only C to 1 or 0, or only I to 1 or 0. The result and all other flags hold.
- R11: Codes 24 to 31 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Execute the operation on `op` at this clock edge |
| op | input | 5 | Operation code (encoding in R2) |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| result | output | 8 | Registered result |
| flags | output | 5 | Registered condition code {H, I, N, Z, C} |

## Verification
Every operation presented with `en` high at one clock edge shows its result and flags right after that edge. The only exception is the reset release, which takes two further edges to pass the internal synchronizer. The bench therefore drives inputs at the falling edge and updates a behavioural model at the same moment. It compares both outputs at the next falling edge, so each comparison covers exactly one executed operation, including the carry flag it carried forward. An asynchronous reset in mid-run is checked one nanosecond after assertion, without waiting for a clock.

// File: rtl/ccr_alu_pkg.sv
package ccr_alu_pkg;

  localparam int FL_W = 5;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_I = 3;
  localparam int FL_H = 4;
  localparam logic [FL_W-1:0] FL_RESET = 5'b01000;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_BIT = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_NEG = 5'd11,
    OP_COM = 5'd12, OP_CLR = 5'd13, OP_TST = 5'd14, OP_LSL = 5'd15,
    OP_LSR = 5'd16, OP_ASR = 5'd17, OP_ROL = 5'd18, OP_ROR = 5'd19,
    OP_SEC = 5'd20, OP_CLC = 5'd21, OP_SEI = 5'd22, OP_CLI = 5'd23
  } alu_op_e;

  typedef enum logic [1:0] {U_ARITH, U_LOGIC, U_SHIFT, U_NONE} unit_e;
  typedef enum logic [2:0] {LG_AND, LG_OR, LG_XOR, LG_COM, LG_CLR, LG_PASS} lg_fn_e;
  typedef enum logic [2:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROL, SH_ROR} sh_fn_e;
  typedef enum logic [2:0] {CS_KEEP, CS_ARITH, CS_SHIFT, CS_ONE, CS_ZERO} c_src_e;
  typedef enum logic [1:0] {IS_KEEP, IS_SET, IS_CLR} i_src_e;
  typedef enum logic [1:0] {YS_B, YS_ONE, YS_A} y_sel_e;

  typedef struct packed {
    unit_e  unit;
    lg_fn_e lg_fn;
    sh_fn_e sh_fn;
    logic   ar_sub;
    logic   ar_use_c;
    logic   ar_x_zero;
    y_sel_e ar_y;
    logic   wr_res;
    logic   upd_nz;
    logic   upd_h;
    c_src_e c_src;
    i_src_e i_src;
  } alu_ctl_t;

endpackage

// File: rtl/ccr_alu_decode.sv
module ccr_alu_decode
  import ccr_alu_pkg::*;
(
  input  logic [4:0] op,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl           = '0;
    ctl.unit      = U_NONE;
    ctl.lg_fn     = LG_PASS;
    ctl.sh_fn     = SH_LSL;
    ctl.ar_y      = YS_B;
    ctl.c_src     = CS_KEEP;
    ctl.i_src     = IS_KEEP;
    case (op)
      OP_ADD, OP_ADC: begin
        ctl.unit     = U_ARITH;
        ctl.ar_use_c = (op == OP_ADC);
        ctl.wr_res   = 1'b1;
        ctl.upd_nz   = 1'b1;
        ctl.upd_h    = 1'b1;
        ctl.c_src    = CS_ARITH;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ctl.unit     = U_ARITH;
        ctl.ar_sub   = 1'b1;
        ctl.ar_use_c = (op == OP_SBC);
        ctl.wr_res   = (op != OP_CMP);
        ctl.upd_nz   = 1'b1;
        ctl.c_src    = CS_ARITH;
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT: begin
        ctl.unit   = U_LOGIC;
        ctl.lg_fn  = (op == OP_OR)  ? LG_OR :
                     (op == OP_XOR) ? LG_XOR : LG_AND;
        ctl.wr_res = (op != OP_BIT);
        ctl.upd_nz = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctl.unit   = U_ARITH;
        ctl.ar_sub = (op == OP_DEC);
        ctl.ar_y   = YS_ONE;
        ctl.wr_res = 1'b1;
        ctl.upd_nz = 1'b1;
      end
      OP_NEG: begin
        ctl.unit      = U_ARITH;
        ctl.ar_sub    = 1'b1;
        ctl.ar_x_zero = 1'b1;
        ctl.ar_y      = YS_A;
        ctl.wr_res    = 1'b1;
        ctl.upd_nz    = 1'b1;
        ctl.c_src     = CS_ARITH;
      end
      OP_COM: begin
        ctl.unit   = U_LOGIC;
        ctl.lg_fn  = LG_COM;
        ctl.wr_res = 1'b1;
        ctl.upd_nz = 1'b1;
        ctl.c_src  = CS_ONE;
      end
      OP_CLR: begin
        ctl.unit   = U_LOGIC;
        ctl.lg_fn  = LG_CLR;
        ctl.wr_res = 1'b1;
        ctl.upd_nz = 1'b1;
      end
      OP_TST: begin
        ctl.unit   = U_LOGIC;
        ctl.lg_fn  = LG_PASS;
        ctl.upd_nz = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        ctl.unit   = U_SHIFT;
        ctl.sh_fn  = (op == OP_LSR) ? SH_LSR :
                     (op == OP_ASR) ? SH_ASR :
                     (op == OP_ROL) ? SH_ROL :
                     (op == OP_ROR) ? SH_ROR : SH_LSL;
        ctl.wr_res = 1'b1;
        ctl.upd_nz = 1'b1;
        ctl.c_src  = CS_SHIFT;
      end
      OP_SEC: ctl.c_src = CS_ONE;
      OP_CLC: ctl.c_src = CS_ZERO;
      OP_SEI: ctl.i_src = IS_SET;
      OP_CLI: ctl.i_src = IS_CLR;
      default: ;
    endcase
  end

endmodule

// File: rtl/ccr_alu_arith.sv
module ccr_alu_arith #(
  parameter int DW   = 8,
  parameter int HBIT = 4
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          half
);

  localparam int EW = DW + 1;

  logic [EW-1:0] ext;

  always_comb begin
    if (sub) begin
      ext = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
    end else begin
      ext = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
    end
    res  = ext[DW-1:0];
    cout = ext[DW];
    half = x[HBIT] ^ y[HBIT] ^ ext[HBIT];
  end

endmodule

// File: rtl/ccr_alu_logic.sv
module ccr_alu_logic
  import ccr_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  lg_fn_e        fn,
  output logic [DW-1:0] res
);

  always_comb begin
    case (fn)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      LG_COM:  res = ~a;
      LG_CLR:  res = '0;
      LG_PASS: res = a;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/ccr_alu_shift.sv
module ccr_alu_shift
  import ccr_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  sh_fn_e        fn,
  output logic [DW-1:0] res,
  output logic          cout
);

  localparam int MSB = DW - 1;

  always_comb begin
    case (fn)
      SH_LSL: begin res = {a[MSB-1:0], 1'b0};  cout = a[MSB]; end
      SH_LSR: begin res = {1'b0, a[MSB:1]};    cout = a[0];   end
      SH_ASR: begin res = {a[MSB], a[MSB:1]};  cout = a[0];   end
      SH_ROL: begin res = {a[MSB-1:0], cin};   cout = a[MSB]; end
      SH_ROR: begin res = {cin, a[MSB:1]};     cout = a[0];   end
      default: begin res = a; cout = cin; end
    endcase
  end

endmodule

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_alu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int HBIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [4:0]      op,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic [DW-1:0]   result,
  output logic [FL_W-1:0] flags
);

  localparam int MSB = DW - 1;

  // reset synchronizer: asynchronous assert, two-flop release
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  alu_ctl_t ctl;

  ccr_alu_decode u_dec (
    .op  (op),
    .ctl (ctl)
  );

  // arithmetic operand selection
  logic [DW-1:0] ar_x, ar_y, ar_res, lg_res, sh_res, alu_res;
  logic          ar_cin, ar_cout, ar_half, sh_cout;

  always_comb begin
    ar_x   = ctl.ar_x_zero ? '0 : opa;
    case (ctl.ar_y)
      YS_ONE:  ar_y = {{(DW-1){1'b0}}, 1'b1};
      YS_A:    ar_y = opa;
      default: ar_y = opb;
    endcase
    ar_cin = ctl.ar_use_c & flags[FL_C];
  end

  ccr_alu_arith #(.DW(DW), .HBIT(HBIT)) u_arith (
    .x    (ar_x),
    .y    (ar_y),
    .cin  (ar_cin),
    .sub  (ctl.ar_sub),
    .res  (ar_res),
    .cout (ar_cout),
    .half (ar_half)
  );

  ccr_alu_logic #(.DW(DW)) u_logic (
    .a   (opa),
    .b   (opb),
    .fn  (ctl.lg_fn),
    .res (lg_res)
  );

  ccr_alu_shift #(.DW(DW)) u_shift (
    .a    (opa),
    .cin  (flags[FL_C]),
    .fn   (ctl.sh_fn),
    .res  (sh_res),
    .cout (sh_cout)
  );

  always_comb begin
    case (ctl.unit)
      U_ARITH: alu_res = ar_res;
      U_LOGIC: alu_res = lg_res;
      U_SHIFT: alu_res = sh_res;
      default: alu_res = opa;
    endcase
  end

  // next state
  logic [DW-1:0]   result_d;
  logic [FL_W-1:0] flags_d;

  always_comb begin
    result_d = result;
    flags_d  = flags;
    if (en) begin
      if (ctl.wr_res) result_d = alu_res;
      if (ctl.upd_nz) begin
        flags_d[FL_N] = alu_res[MSB];
        flags_d[FL_Z] = ~|alu_res;
      end
      if (ctl.upd_h) flags_d[FL_H] = ar_half;
      case (ctl.c_src)
        CS_ARITH: flags_d[FL_C] = ar_cout;
        CS_SHIFT: flags_d[FL_C] = sh_cout;
        CS_ONE:   flags_d[FL_C] = 1'b1;
        CS_ZERO:  flags_d[FL_C] = 1'b0;
        default:  ;
      endcase
      case (ctl.i_src)
        IS_SET:  flags_d[FL_I] = 1'b1;
        IS_CLR:  flags_d[FL_I] = 1'b0;
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      result <= '0;
      flags  <= FL_RESET;
    end else begin
      result <= result_d;
      flags  <= flags_d;
    end
  end

endmodule

// File: rtl/ccr_alu_chk.sv
module ccr_alu_chk
  import ccr_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [4:0]      op,
  input logic [DW-1:0]   opa,
  input logic [DW-1:0]   opb,
  input logic [DW-1:0]   result,
  input logic [FL_W-1:0] flags
);

  logic [DW:0] add_sum;
  logic        writes_nz;

  always_comb begin
    add_sum = {1'b0, opa} + {1'b0, opb};
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_XOR,
      OP_INC, OP_DEC, OP_NEG, OP_COM, OP_CLR,
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: writes_nz = 1'b1;
      default: writes_nz = 1'b0;
    endcase
  end

  p_zero_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en && writes_nz |=> flags[FL_Z] == (result == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(result) && $stable(flags));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_ADD |=> flags[FL_C] == $past(add_sum[DW]));

  p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_SUB |=> flags[FL_C] == $past(opb > opa));

  p_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_CMP || op == OP_BIT || op == OP_TST) |=> $stable(result));

  p_logic_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_AND || op == OP_OR || op == OP_XOR)
    |=> $stable(flags[FL_H:FL_I]) && $stable(flags[FL_C]));

  p_incdec_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_INC || op == OP_DEC)
    |=> $stable(flags[FL_H:FL_I]) && $stable(flags[FL_C]));

  p_set_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_SEC |=> flags[FL_C] && $stable(flags[FL_H:FL_Z]) && $stable(result));

  p_clear_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_CLI |=> !flags[FL_I] && $stable(result));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en && op > OP_CLI |=> $stable(result) && $stable(flags));

endmodule

bind ccr_alu ccr_alu_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .en     (en),
  .op     (op),
  .opa    (opa),
  .opb    (opb),
  .result (result),
  .flags  (flags)
);

// File: tb/ccr_alu_tb_top.sv
`timescale 1ns/1ps
module ccr_alu_tb_top;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [4:0] op;
  logic [7:0] opa, opb;
  logic [7:0] result;
  logic [4:0] flags;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;

  logic [7:0] m_res;
  logic [4:0] m_flg;

  ccr_alu dut_i (
    .clk (clk), .rst_n (rst_n), .en (en), .op (op),
    .opa (opa), .opb (opb), .result (result), .flags (flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference: flags {H,I,N,Z,C}
  task automatic model(input int o, input int a, input int b);
    int c, r, s;
    bit wr, nz;
    c  = int'(m_flg[0]);
    r  = 0;
    wr = 0;
    nz = 0;
    case (o)
      0, 1: begin
        s = a + b + ((o == 1) ? c : 0);
        r = s & 255; wr = 1; nz = 1;
        m_flg[0] = (s > 255);
        m_flg[4] = (((a ^ b ^ r) >> 4) & 1) != 0;
      end
      2, 3, 4: begin
        s = a - b - ((o == 3) ? c : 0);
        r = s & 255; nz = 1; wr = (o != 4);
        m_flg[0] = (s < 0);
      end
      5: begin r = a & b; wr = 1; nz = 1; end
      6: begin r = a | b; wr = 1; nz = 1; end
      7: begin r = a ^ b; wr = 1; nz = 1; end
      8: begin r = a & b; nz = 1; end
      9:  begin r = (a + 1) & 255;   wr = 1; nz = 1; end
      10: begin r = (a + 255) & 255; wr = 1; nz = 1; end
      11: begin r = (256 - a) & 255; wr = 1; nz = 1; m_flg[0] = (a != 0); end
      12: begin r = 255 - a;         wr = 1; nz = 1; m_flg[0] = 1'b1; end
      13: begin r = 0;               wr = 1; nz = 1; end
      14: begin r = a; nz = 1; end
      15: begin r = (a * 2) & 255;           m_flg[0] = (a >= 128); wr = 1; nz = 1; end
      16: begin r = a / 2;                   m_flg[0] = (a % 2) != 0; wr = 1; nz = 1; end
      17: begin r = (a / 2) + (a & 128);     m_flg[0] = (a % 2) != 0; wr = 1; nz = 1; end
      18: begin r = ((a * 2) & 255) + c;     m_flg[0] = (a >= 128); wr = 1; nz = 1; end
      19: begin r = (a / 2) + c * 128;       m_flg[0] = (a % 2) != 0; wr = 1; nz = 1; end
      20: m_flg[0] = 1'b1;
      21: m_flg[0] = 1'b0;
      22: m_flg[3] = 1'b1;
      23: m_flg[3] = 1'b0;
      default: ;
    endcase
    if (nz) begin
      m_flg[2] = (r >= 128);
      m_flg[1] = (r == 0);
    end
    if (wr) m_res = r[7:0];
  endtask

  function automatic string tag_of(input int o, input bit e);
    if (!e) return "R2";
    case (o)
      0, 1:               return "R3";
      2, 3:               return "R4";
      4, 8, 14:           return "R5";
      5, 6, 7:            return "R6";
      9, 10:              return "R7";
      11, 12, 13:         return "R8";
      15, 16, 17, 18, 19: return "R9";
      20, 21, 22, 23:     return "R10";
      default:            return "R11";
    endcase
  endfunction

  task automatic check(input string tag);
    n_tests++;
    if (result !== m_res || flags !== m_flg) begin
      n_fail++;
      $display("FAIL %s: result=%02h flags=%02h expected result=%02h flags=%02h",
               tag, result, flags, m_res, m_flg);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input int o, input int a, input int b, input bit e, input string tag);
    en  = e;
    op  = o[4:0];
    opa = a[7:0];
    opb = b[7:0];
    if (e) model(o, a, b);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; op = '0; opa = '0; opb = '0;
    m_res = 8'h00; m_flg = 5'b01000;
    repeat (3) @(negedge clk);
    check("R1");                       // reset state while held
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");                       // reset state after release

    // R3 add and half carry
    step(0, 8'h0F, 8'h01, 1, "R3");     // 0x10, H=1
    step(0, 8'hFF, 8'h01, 1, "R3");     // 0x00, C=1 Z=1
    step(1, 8'h10, 8'h20, 1, "R3");     // with carry in -> 0x31
    step(0, 8'h70, 8'h10, 1, "R3");     // 0x80 N=1
    // R4 subtract with borrow
    step(2, 8'h10, 8'h20, 1, "R4");     // 0xF0 C=1
    step(3, 8'h05, 8'h05, 1, "R4");     // 5-5-1 = 0xFF C=1
    step(3, 8'h05, 8'h04, 1, "R4");     // 5-4-1 = 0x00 Z=1 C=0
    // R5 compare, bit test, test keep result
    step(0, 8'h22, 8'h11, 1, "R3");
    step(4, 8'h40, 8'h40, 1, "R5");     // Z=1, result stays 0x33
    step(4, 8'h01, 8'h02, 1, "R5");     // C=1 N=1
    step(8, 8'hF0, 8'h0F, 1, "R5");
    step(14, 8'h80, 8'h00, 1, "R5");
    // R6 logic
    step(5, 8'hF0, 8'h0F, 1, "R6");
    step(6, 8'h80, 8'h01, 1, "R6");
    step(7, 8'hAA, 8'hAA, 1, "R6");
    // R7 inc/dec with carry held
    step(20, 0, 0, 1, "R10");
    step(9, 8'hFF, 0, 1, "R7");
    step(10, 8'h00, 0, 1, "R7");
    step(21, 0, 0, 1, "R10");
    step(9, 8'h7F, 0, 1, "R7");
    // R8 negate, complement, clear
    step(11, 8'h00, 0, 1, "R8");
    step(11, 8'h01, 0, 1, "R8");
    step(12, 8'h5A, 0, 1, "R8");
    step(13, 8'h77, 0, 1, "R8");
    // R9 shifts and rotates, both carry values
    step(15, 8'h81, 0, 1, "R9");
    step(18, 8'h40, 0, 1, "R9");
    step(19, 8'h02, 0, 1, "R9");
    step(16, 8'h81, 0, 1, "R9");
    step(17, 8'h81, 0, 1, "R9");
    step(19, 8'h00, 0, 1, "R9");
    // R10 mask flag commands
    step(23, 0, 0, 1, "R10");
    step(22, 0, 0, 1, "R10");
    // R11 reserved codes
    step(24, 8'h12, 8'h34, 1, "R11");
    step(31, 8'hFF, 8'hFF, 1, "R11");
    // R2 enable low
    step(13, 0, 0, 0, "R2");
    step(20, 0, 0, 0, "R2");

    for (int i = 0; i < 800; i++) begin
      int o, a, b;
      bit e;
      o = int'($urandom_range(31, 0));
      a = int'($urandom_range(255, 0));
      b = int'($urandom_range(255, 0));
      e = ($urandom_range(7, 0) != 0);
      step(o, a, b, e, tag_of(o, e));
    end

    // R1 asynchronous reset in mid-run
    step(12, 8'h00, 0, 1, "R8");
    en = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    m_res = 8'h00; m_flg = 5'b01000;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule